// File: doc/BRIEF.md
# Ternary Match Route Lookup Engine

This block resolves a 32-bit destination address to a next-hop value by searching a table of ternary entries. Each entry stores a value, a care mask, a next-hop word and a valid flag. A key bit is compared against an entry bit only where the entry's care bit is 1. Where the care bit is 0, that bit matches any key bit. A prefix of length L is written as a care mask with its upper L bits set.

Every entry is compared against the key in the same cycle. When several entries match, the one at the lowest index wins. Software outside the block stores longer prefixes at lower indices, so the first match is the longest one. The result is registered, so it appears one clock after the key is presented. It carries a hit flag, the winning index and the next hop. On a miss, the block returns a programmable default next hop.

Top module: `tcam_lpm`

## Requirements
- R1: After synchronous reset, `rsp_valid` and `rsp_hit` are 0 and every entry is invalid. A search then misses and returns next hop 0.
- R2: A key bit whose entry care bit is 0 never prevents a match. An entry with an all-zero care mask matches every key.
- R3: A key bit whose entry care bit is 1 must equal the stored value bit. A single differing cared bit makes that entry not match.
- R4: When several valid entries match, the entry with the lowest index wins. This holds up to and including index DEPTH-1. `rsp_idx` reports the winner and `rsp_hop` reports its next hop.
- R5: An entry written with its valid bit at 0 never matches, whatever its value and mask.
- R6: On a miss, `rsp_hit` is 0, `rsp_idx` is 0 and `rsp_hop` equals the default next hop last loaded through `dflt_we`/`dflt_hop`.
- R7: A search presented with `srch_en` high in cycle t gives its result, with `rsp_valid` high, in cycle t+1. `rsp_valid` is low in the cycle after any cycle without `srch_en`. Back-to-back searches return results in order, one per cycle.
- R8: A table write in the same cycle as a search does not affect that search. The write is seen by searches from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Valid flag for the written entry |
| cfg_value | input | KEY_W | Stored value bits |
| cfg_care | input | KEY_W | Care mask (1 = compare, 0 = don't care) |
| cfg_hop | input | HOP_W | Next hop for the written entry |
| dflt_we | input | 1 | Load the miss next hop |
| dflt_hop | input | HOP_W | Next hop returned on a miss |
| srch_en | input | 1 | Search request this cycle |
| srch_key | input | KEY_W | Search key |
| rsp_valid | output | 1 | Result of the previous cycle's search is present |
| rsp_hit | output | 1 | At least one entry matched |
| rsp_idx | output | IDX_W | Index of the winning entry (0 on a miss) |
| rsp_hop | output | HOP_W | Winning or default next hop |

## Verification
A stale or corrupted valid bit, value or mask shows up on the very next response. It appears as a wrong hit flag, a wrong winner index or a wrong next hop for a key aimed at that entry. A broken priority order shows only when more than one entry matches, so the keys are chosen to fall under nested prefixes. A write ordering fault shows on the two searches that straddle the write cycle: the first must still return the old winner and the second the new one.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int KEY_W_DEF = 32;
  localparam int HOP_W_DEF = 8;
  localparam int DEPTH_DEF = 32;

  function automatic logic ternary_eq(input logic [63:0] key,
                                      input logic [63:0] value,
                                      input logic [63:0] care);
    return ((key ^ value) & care) == '0;
  endfunction
endpackage

// File: rtl/tcam_store.sv
module tcam_store
  import tcam_pkg::*;
#(
  parameter int KEY_W = KEY_W_DEF,
  parameter int HOP_W = HOP_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_valid,
  input  logic [KEY_W-1:0]            wr_value,
  input  logic [KEY_W-1:0]            wr_care,
  input  logic [HOP_W-1:0]            wr_hop,
  input  logic [KEY_W-1:0]            key,
  output logic [DEPTH-1:0]            match_vec,
  output logic [DEPTH-1:0][HOP_W-1:0] hop_tab
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic             vld_q;
    logic [KEY_W-1:0] val_q;
    logic [KEY_W-1:0] care_q;
    logic [HOP_W-1:0] hop_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst)      vld_q <= 1'b0;
      else if (sel) vld_q <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        val_q  <= wr_value;
        care_q <= wr_care;
        hop_q  <= wr_hop;
      end
    end

    assign match_vec[e] = vld_q &&
                          ternary_eq(64'(key), 64'(val_q), 64'(care_q));
    assign hop_tab[e]   = hop_q;
  end

endmodule

// File: rtl/tcam_first_hit.sv
module tcam_first_hit #(
  parameter int DEPTH = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tcam_lpm.sv
module tcam_lpm
  import tcam_pkg::*;
#(
  parameter int KEY_W = KEY_W_DEF,
  parameter int HOP_W = HOP_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [KEY_W-1:0] cfg_value,
  input  logic [KEY_W-1:0] cfg_care,
  input  logic [HOP_W-1:0] cfg_hop,
  input  logic             dflt_we,
  input  logic [HOP_W-1:0] dflt_hop,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [HOP_W-1:0] rsp_hop
);

  logic [DEPTH-1:0]            match_vec;
  logic [DEPTH-1:0][HOP_W-1:0] hop_tab;
  logic                        any_hit;
  logic [IDX_W-1:0]            win_idx;
  logic [HOP_W-1:0]            dflt_q;

  tcam_store #(
    .KEY_W(KEY_W), .HOP_W(HOP_W), .DEPTH(DEPTH)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_valid (cfg_valid),
    .wr_value (cfg_value),
    .wr_care  (cfg_care),
    .wr_hop   (cfg_hop),
    .key      (srch_key),
    .match_vec(match_vec),
    .hop_tab  (hop_tab)
  );

  tcam_first_hit #(.DEPTH(DEPTH)) u_enc (
    .req  (match_vec),
    .found(any_hit),
    .idx  (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst)          dflt_q <= '0;
    else if (dflt_we) dflt_q <= dflt_hop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_hop   <= '0;
    end else begin
      rsp_valid <= srch_en;
      if (srch_en) begin
        rsp_hit <= any_hit;
        rsp_idx <= any_hit ? win_idx : '0;
        rsp_hop <= any_hit ? hop_tab[win_idx] : dflt_q;
      end
    end
  end

endmodule

// File: rtl/tcam_lpm_chk.sv
module tcam_lpm_chk #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             srch_en,
  input logic [DEPTH-1:0] match_vec,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_idx
);

  // R7
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> rsp_valid);

  // R7
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> !rsp_valid);

  // R4
  winner_matched_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |->
      ((($past(match_vec) >> rsp_idx) & DEPTH'(1)) != '0));

  // R4
  winner_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |->
      (($past(match_vec) & ((DEPTH'(1) << rsp_idx) - DEPTH'(1))) == '0));

  // R6
  miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> ($past(match_vec) == '0 && rsp_idx == '0));

endmodule

bind tcam_lpm tcam_lpm_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .srch_en  (srch_en),
  .match_vec(match_vec),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_idx  (rsp_idx)
);

// File: tb/tcam_lpm_tb.sv
module tcam_lpm_tb;
  localparam int KEY_W = 32;
  localparam int HOP_W = 8;
  localparam int DEPTH = 32;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst;
  logic             cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic             cfg_valid = 1'b0;
  logic [KEY_W-1:0] cfg_value = '0;
  logic [KEY_W-1:0] cfg_care = '0;
  logic [HOP_W-1:0] cfg_hop = '0;
  logic             dflt_we = 1'b0;
  logic [HOP_W-1:0] dflt_hop = '0;
  logic             srch_en = 1'b0;
  logic [KEY_W-1:0] srch_key = '0;
  logic             rsp_valid;
  logic             rsp_hit;
  logic [IDX_W-1:0] rsp_idx;
  logic [HOP_W-1:0] rsp_hop;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tcam_lpm #(.KEY_W(KEY_W), .HOP_W(HOP_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_value(cfg_value), .cfg_care(cfg_care), .cfg_hop(cfg_hop),
    .dflt_we(dflt_we), .dflt_hop(dflt_hop),
    .srch_en(srch_en), .srch_key(srch_key),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx), .rsp_hop(rsp_hop)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_rsp(input string req, input logic hit,
                         input int idx, input logic [HOP_W-1:0] hop);
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_hit", 32'(rsp_hit), 32'(hit));
    chk(req, "rsp_idx", 32'(rsp_idx), 32'(idx));
    chk(req, "rsp_hop", 32'(rsp_hop), 32'(hop));
  endtask

  task automatic put(input int idx, input logic vld, input logic [31:0] val,
                     input logic [31:0] care, input logic [HOP_W-1:0] hop);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = vld;
    cfg_value = val; cfg_care = care; cfg_hop = hop;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [31:0] key);
    srch_en = 1'b1; srch_key = key;
    @(negedge clk);
    srch_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "rsp_hit after reset", 32'(rsp_hit), 32'd0);
    look(32'h0A01_0207);
    chk_rsp("R1", 1'b0, 0, 8'h00);
  endtask

  task automatic t_default;
    dflt_we = 1'b1; dflt_hop = 8'hEE;
    @(negedge clk);
    dflt_we = 1'b0;
    look(32'h1234_5678);
    chk_rsp("R6", 1'b0, 0, 8'hEE);
  endtask

  task automatic t_exact;
    put(3, 1'b1, 32'hC0A8_0001, 32'hFFFF_FFFF, 8'h55);
    look(32'hC0A8_0001);
    chk_rsp("R3", 1'b1, 3, 8'h55);
    look(32'hC0A8_0002);
    chk_rsp("R3", 1'b0, 0, 8'hEE);
    look(32'h40A8_0001);
    chk_rsp("R3", 1'b0, 0, 8'hEE);
  endtask

  task automatic t_priority;
    put(0, 1'b1, 32'h0A01_0200, 32'hFFFF_FF00, 8'h11);
    put(1, 1'b1, 32'h0A01_0000, 32'hFFFF_0000, 8'h22);
    put(2, 1'b1, 32'h0A00_0000, 32'hFF00_0000, 8'h33);
    look(32'h0A01_02FE);
    chk_rsp("R4", 1'b1, 0, 8'h11);
    look(32'h0A01_0300);
    chk_rsp("R4", 1'b1, 1, 8'h22);
    look(32'h0A7F_0000);
    chk_rsp("R2", 1'b1, 2, 8'h33);
    put(DEPTH - 1, 1'b1, 32'hAABB_CCDD, 32'hFFFF_FFFF, 8'h66);
    look(32'hAABB_CCDD);
    chk_rsp("R4", 1'b1, DEPTH - 1, 8'h66);
  endtask

  task automatic t_write_collide;
    cfg_we = 1'b1; cfg_idx = IDX_W'(0); cfg_valid = 1'b0;
    cfg_value = 32'h0A01_0200; cfg_care = 32'hFFFF_FF00; cfg_hop = 8'h99;
    srch_en = 1'b1; srch_key = 32'h0A01_0207;
    @(negedge clk);
    cfg_we = 1'b0; srch_en = 1'b0;
    chk_rsp("R8", 1'b1, 0, 8'h11);
    look(32'h0A01_0207);
    chk_rsp("R8", 1'b1, 1, 8'h22);
  endtask

  task automatic t_invalid;
    put(1, 1'b0, 32'h0A01_0000, 32'hFFFF_0000, 8'h22);
    look(32'h0A01_0207);
    chk_rsp("R5", 1'b1, 2, 8'h33);
    put(2, 1'b0, 32'h0000_0000, 32'h0000_0000, 8'h77);
    look(32'h0A01_0207);
    chk_rsp("R5", 1'b0, 0, 8'hEE);
  endtask

  task automatic t_wildcard;
    put(5, 1'b1, 32'hDEAD_BEEF, 32'h0000_0000, 8'h44);
    look(32'h0B00_0000);
    chk_rsp("R2", 1'b1, 5, 8'h44);
    look(32'hC0A8_0001);
    chk_rsp("R4", 1'b1, 3, 8'h55);
  endtask

  task automatic t_stream;
    srch_en = 1'b1; srch_key = 32'hC0A8_0001;
    @(negedge clk);
    chk_rsp("R7", 1'b1, 3, 8'h55);
    srch_key = 32'h0101_0101;
    @(negedge clk);
    chk_rsp("R7", 1'b1, 5, 8'h44);
    srch_key = 32'hAABB_CCDD;
    @(negedge clk);
    srch_en = 1'b0;
    chk_rsp("R7", 1'b1, 5, 8'h44);
    @(negedge clk);
    chk("R7", "rsp_valid idle", 32'(rsp_valid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default();
    t_exact();
    t_priority();
    t_write_collide();
    t_invalid();
    t_wildcard();
    t_stream();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule